// File: doc/BRIEF.md
# Striped address request splitter

This block turns one transfer request into the sequence of per-block commands that a set of DMA target channels consumes. A request names a starting sector, a length in 512-byte sectors and a kind: read, write or discard. The block converts the sector number to a byte address. It cuts the transfer so that no piece crosses a 4096-byte hardware block boundary. It then steers each piece to one of a power-of-two number of targets, using the address bits just above the stripe size.

For every piece the block presents the target index and a logical block address. The logical block address is the byte address with the target-select bits squeezed out, then divided by 4096. The block also presents a 3-bit sub-block offset, a 3-bit sub-block count and the piece length in bytes. Pieces leave through a valid/ready handshake. The stripe size (in bytes) and the log2 of the target count are configuration inputs. They are to be held steady while a request is in progress.

Top module: `stripe_splitter`

## Requirements
- R1: After reset no piece is presented (`ck_valid` low) and, with a legal configuration, `req_ready` is high.
- R2: A stripe size that is zero or not a power of two raises `cfg_err`. While `cfg_err` is high, `req_ready` stays low, requests are not taken and no piece appears.
- R3: The target index of a piece equals (byte address >> log2(stripe size)) AND (2^`cfg_tgt_log2` − 1), where the byte address is that of the piece's first byte.
- R4: The logical block address equals ((byte address >> `cfg_tgt_log2`) AND NOT(stripe−1) OR (byte address AND (stripe−1))) >> 12.
- R5: The byte address of the first piece is the request's starting sector times 512.
- R6: For reads and writes, each piece covers the smaller of the remaining sectors and the sectors left to the end of the current 4096-byte block. Pieces come out in ascending address order, and together they cover the request exactly.
- R7: For reads and writes, `ck_sub_off` is byte address bits [11:9]. `ck_sub_cnt` is the piece length in sectors modulo 8, where 0 means a full block. `ck_bytes` is the piece length in bytes (count×512, or 4096 when the count is zero).
- R8: A discard is cut into whole blocks. Each piece has sub-block offset 0, count 0 and `ck_bytes` 4096, and the address advances by 4096 from one piece to the next. The request yields ceil(length/8) pieces.
- R9: While `ck_valid` is high and `ck_ready` low, every piece output holds its value. `req_ready` is low from the request's acceptance until the cycle after the last piece's handshake.
- R10: A request of zero sectors is accepted and produces no piece, and `req_ready` is high again in the next cycle.
- R11: `ck_write` is high for every piece of a write request and low for reads and discards. `ck_discard` marks the pieces of a discard. When both request flags are set, discard takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stripe_bytes | input | SECT_W+9 | Stripe size in bytes, must be a power of two |
| cfg_tgt_log2 | input | clog2(TGT_LOG2_MAX+1) | log2 of the number of targets |
| cfg_err | output | 1 | Stripe size is illegal |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_sector | input | SECT_W | Starting sector number |
| req_nsect | input | LEN_W | Length in 512-byte sectors |
| req_write | input | 1 | Write (else read) |
| req_discard | input | 1 | Discard request |
| ck_valid | output | 1 | Piece presented |
| ck_ready | input | 1 | Consumer takes the piece |
| ck_target | output | TGT_LOG2_MAX | Target index |
| ck_lba | output | SECT_W−3 | Logical block address |
| ck_sub_off | output | 3 | Sector offset inside the block |
| ck_sub_cnt | output | 3 | Sector count, 0 = full block |
| ck_bytes | output | 13 | Piece length in bytes |
| ck_write | output | 1 | Piece belongs to a write |
| ck_discard | output | 1 | Piece belongs to a discard |

## Verification
The hardest case to reach is a consumer stall that lands on a piece in the middle of an unaligned request. It exercises the case where the remaining count, the block-boundary limit and the held outputs all interact. The stimulus reaches it by starting requests at odd sectors with lengths that end mid-block, and by withholding `ck_ready` for one cycle on every piece. Each piece is compared against the striping formulas, evaluated independently for several stripe sizes, including stripes smaller than a block, and for one, two, four and eight targets.

// File: rtl/stripe_splitter.sv
module stripe_splitter #(
  parameter int SECT_W       = 23,
  parameter int LEN_W        = 16,
  parameter int TGT_LOG2_MAX = 3,
  localparam int ADDR_W = SECT_W + 9,
  localparam int LBA_W  = ADDR_W - 12,
  localparam int TGT_W  = (TGT_LOG2_MAX > 0) ? TGT_LOG2_MAX : 1,
  localparam int NL_W   = (TGT_LOG2_MAX > 0) ? $clog2(TGT_LOG2_MAX + 1) : 1,
  localparam int SL_W   = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_stripe_bytes,
  input  logic [NL_W-1:0]   cfg_tgt_log2,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SECT_W-1:0] req_sector,
  input  logic [LEN_W-1:0]  req_nsect,
  input  logic              req_write,
  input  logic              req_discard,
  output logic              ck_valid,
  input  logic              ck_ready,
  output logic [TGT_W-1:0]  ck_target,
  output logic [LBA_W-1:0]  ck_lba,
  output logic [2:0]        ck_sub_off,
  output logic [2:0]        ck_sub_cnt,
  output logic [12:0]       ck_bytes,
  output logic              ck_write,
  output logic              ck_discard
);

  logic              busy;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  rem;
  logic              wr_q, disc_q;

  logic [ADDR_W-1:0] lower, tmask, merged;
  logic [SL_W-1:0]   slog;
  logic [3:0]        room, csect;

  assign lower   = cfg_stripe_bytes - ADDR_W'(1);
  assign cfg_err = (cfg_stripe_bytes == '0) || ((cfg_stripe_bytes & lower) != '0);

  always_comb begin
    slog = '0;
    for (int i = 0; i < ADDR_W; i++)
      if (cfg_stripe_bytes[i]) slog = SL_W'(i);
  end

  assign tmask  = (ADDR_W'(1) << cfg_tgt_log2) - ADDR_W'(1);
  assign merged = ((addr >> cfg_tgt_log2) & ~lower) | (addr & lower);

  assign room  = disc_q ? 4'd8 : 4'd8 - {1'b0, addr[11:9]};
  assign csect = (rem < LEN_W'(room)) ? rem[3:0] : room;

  assign req_ready  = !busy && !cfg_err;
  assign ck_valid   = busy;
  assign ck_target  = TGT_W'((addr >> slog) & tmask);
  assign ck_lba     = merged[ADDR_W-1:12];
  assign ck_sub_off = disc_q ? 3'd0 : addr[11:9];
  assign ck_sub_cnt = disc_q ? 3'd0 : csect[2:0];
  assign ck_bytes   = disc_q ? 13'd4096 : {csect, 9'd0};
  assign ck_write   = wr_q && !disc_q;
  assign ck_discard = disc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr   <= '0;
      rem    <= '0;
      wr_q   <= 1'b0;
      disc_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      busy   <= (req_nsect != '0);
      addr   <= {req_sector, 9'd0};
      rem    <= req_nsect;
      wr_q   <= req_write;
      disc_q <= req_discard;
    end else if (ck_valid && ck_ready) begin
      addr <= addr + ADDR_W'(ck_bytes);
      rem  <= (rem > LEN_W'(csect)) ? rem - LEN_W'(csect) : '0;
      if (rem <= LEN_W'(csect)) busy <= 1'b0;
    end
  end

  a_r2_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !req_ready);
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ck_valid |-> !req_ready);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid && !ck_ready) |=> (ck_valid && $stable(ck_lba) && $stable(ck_target)
                                 && $stable(ck_bytes) && $stable(ck_sub_off)));
  a_r6_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid && !ck_discard) |->
      ({1'b0, ck_sub_off} + ((ck_sub_cnt == 3'd0) ? 4'd8 : {1'b0, ck_sub_cnt})) <= 4'd8);
  a_r7_bytes_match: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid && !ck_discard) |->
      ck_bytes == ((ck_sub_cnt == 3'd0) ? 13'd4096 : {1'b0, ck_sub_cnt, 9'd0}));
  a_r8_discard_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid && ck_discard) |-> (ck_sub_off == 3'd0 && ck_sub_cnt == 3'd0 && ck_bytes == 13'd4096));
  a_r11_kind_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ck_valid |-> !(ck_write && ck_discard));

endmodule

// File: tb/sim_stripe_splitter.sv
module sim_stripe_splitter;
  localparam int SECT_W = 23, LEN_W = 16, TGT_LOG2_MAX = 3;
  localparam int ADDR_W = SECT_W + 9;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] cfg_stripe_bytes = 32'd8192;
  logic [1:0]  cfg_tgt_log2 = 2'd2;
  logic        cfg_err, req_valid = 0, req_ready, req_write = 0, req_discard = 0;
  logic [SECT_W-1:0] req_sector = '0;
  logic [LEN_W-1:0]  req_nsect = '0;
  logic        ck_valid, ck_ready = 0, ck_write, ck_discard;
  logic [2:0]  ck_target, ck_sub_off, ck_sub_cnt;
  logic [19:0] ck_lba;
  logic [12:0] ck_bytes;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  stripe_splitter #(.SECT_W(SECT_W), .LEN_W(LEN_W), .TGT_LOG2_MAX(TGT_LOG2_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_stripe_bytes(cfg_stripe_bytes), .cfg_tgt_log2(cfg_tgt_log2),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready), .req_sector(req_sector),
    .req_nsect(req_nsect), .req_write(req_write), .req_discard(req_discard),
    .ck_valid(ck_valid), .ck_ready(ck_ready), .ck_target(ck_target), .ck_lba(ck_lba),
    .ck_sub_off(ck_sub_off), .ck_sub_cnt(ck_sub_cnt), .ck_bytes(ck_bytes),
    .ck_write(ck_write), .ck_discard(ck_discard));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic run_req(input longint sector, input int nsect, input bit wr, input bit disc,
                         input bit stall);
    longint addr, stripe, lba, tgt, off, cs, bytes, ecnt;
    int rem, n, wait_n;
    addr = sector * 512;                                  // R5
    stripe = longint'(cfg_stripe_bytes);
    rem = nsect;
    chk("R9 ready before request", req_ready, 1);
    req_valid = 1; req_sector = SECT_W'(sector); req_nsect = LEN_W'(nsect);
    req_write = wr; req_discard = disc;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (rem > 0) begin
      wait_n = 0;
      while (!ck_valid && wait_n < 20) begin @(negedge clk); wait_n++; end
      chk("R6 piece present", ck_valid, 1);
      if (!ck_valid) return;
      off = (addr >> 9) & 7;
      if (disc) begin
        cs = (rem < 8) ? rem : 8; bytes = 4096; ecnt = 0;
        chk("R8 discard offset", ck_sub_off, 0);
      end else begin
        cs = (rem < 8 - off) ? rem : 8 - off; bytes = cs * 512; ecnt = cs & 7;
        chk("R7 sub offset", ck_sub_off, off);
      end
      tgt = (addr >> $clog2(stripe)) & ((longint'(1) << cfg_tgt_log2) - 1);
      lba = (((addr >> cfg_tgt_log2) & ~(stripe - 1)) | (addr & (stripe - 1))) >> 12;
      chk("R3 target", ck_target, tgt);
      chk("R4 lba", ck_lba, lba);
      chk(disc ? "R8 discard count" : "R7 sub count", ck_sub_cnt, ecnt);
      chk(disc ? "R8 discard bytes" : "R6 piece bytes", ck_bytes, bytes);
      chk("R11 write flag", ck_write, wr && !disc);
      chk("R11 discard flag", ck_discard, disc);
      chk("R9 busy blocks request", req_ready, 0);
      if (stall) begin
        ck_ready = 0;
        @(negedge clk);
        chk("R9 held valid", ck_valid, 1);
        chk("R9 held lba", ck_lba, lba);
        chk("R9 held bytes", ck_bytes, bytes);
      end
      ck_ready = 1;
      @(negedge clk);
      ck_ready = 0;
      addr += disc ? 4096 : bytes;
      rem -= cs;
      n++;
    end
    chk("R6 no extra piece", ck_valid, 0);
    chk("R9 ready after last", req_ready, 1);
    if (disc) chk("R8 piece total", n, (nsect + 7) / 8);
  endtask

  task automatic t_reset();
    chk("R1 valid low", ck_valid, 0);
    chk("R1 ready high", req_ready, 1);
    chk("R2 no error", cfg_err, 0);
  endtask

  task automatic t_cfg_err();
    cfg_stripe_bytes = 32'd12288;
    @(negedge clk);
    chk("R2 err flag", cfg_err, 1);
    chk("R2 ready low", req_ready, 0);
    req_valid = 1; req_nsect = 16'd4; req_sector = '0;
    @(negedge clk); @(negedge clk);
    req_valid = 0;
    chk("R2 no piece", ck_valid, 0);
    cfg_stripe_bytes = 32'd0;
    @(negedge clk);
    chk("R2 zero stripe", cfg_err, 1);
    cfg_stripe_bytes = 32'd8192;
    @(negedge clk);
    chk("R2 legal again", cfg_err, 0);
    chk("R2 no late piece", ck_valid, 0);
  endtask

  task automatic t_zero_len();
    req_valid = 1; req_nsect = '0; req_sector = 23'd77;
    @(negedge clk);
    req_valid = 0;
    chk("R10 no piece", ck_valid, 0);
    chk("R10 ready", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg_err();
    run_req(0, 16, 1, 0, 0);
    run_req(5, 13, 0, 0, 1);
    run_req(3, 20, 0, 1, 1);
    t_zero_len();
    cfg_stripe_bytes = 32'd4096; cfg_tgt_log2 = 2'd3;
    @(negedge clk);
    run_req(1000, 40, 1, 0, 0);
    run_req(23'h12345, 9, 0, 0, 1);
    cfg_stripe_bytes = 32'd512; cfg_tgt_log2 = 2'd1;
    @(negedge clk);
    run_req(7, 18, 1, 0, 1);
    run_req(8, 16, 1, 1, 0);
    cfg_stripe_bytes = 32'd65536; cfg_tgt_log2 = 2'd0;
    @(negedge clk);
    run_req(300, 25, 0, 0, 0);
    finish_run();
  end
endmodule